// File: doc/BRIEF.md
# Direction-Configurable Split Byte FIFO

This block holds the byte buffering for one serial channel. A single store of 64 byte entries is shared between the transmit and receive directions. If only one direction has buffering turned on, that direction gets the whole store as one 64-deep FIFO. If both directions have it, the store is split into two independent 32-deep FIFOs. Each FIFO keeps its own read and write positions, and each wraps within its own half.

Each direction has a write port and a read port. Read data is show-ahead: the oldest entry is on the read-data output whenever the FIFO is not empty. Every direction reports empty, full, almost-empty and almost-full. The two almost-flags are compared against two programmable levels, and each FIFO reads those levels against its own current depth. A scheduler uses the flags to decide whether a channel may transmit and whether it must stop receiving. Changing which directions are buffered empties both FIFOs.

Top module: `shared_dir_fifo`

## Requirements
- R1: With `tx_buf_en`=1 and `rx_buf_en`=0, the transmit FIFO holds 64 bytes and returns them in the order they were written; the transmit full flag rises after the 64th accepted write.
- R2: With `rx_buf_en`=1 and `tx_buf_en`=0, the receive FIFO holds 64 bytes in first-in first-out order; its full flag rises after the 64th accepted write.
- R3: With both enables set, each direction holds exactly 32 bytes, and traffic on one direction never changes the contents or flags of the other.
- R4: A write while full is ignored and a read while empty is ignored. Fullness and emptiness are taken from the state before the clock edge, so a write to a full FIFO is dropped even when a read happens in the same cycle.
- R5: If the pair {`rx_buf_en`,`tx_buf_en`} on a clock edge differs from its value at the previous edge, both FIFOs are emptied at that edge. All reads and writes presented in that cycle are ignored.
- R6: A direction whose enable is 0 reports empty=1, full=1, almost-empty=0 and almost-full=0, and its reads and writes have no effect.
- R7: The almost-empty flag of an enabled direction is 1 exactly when its entry count is less than or equal to `ae_level`.
- R8: The almost-full flag of an enabled direction is 1 exactly when its entry count is greater than or equal to `af_level`. In split mode the levels are compared against 32-entry counts.
- R9: While a FIFO is not empty, its read-data output shows the oldest stored byte. The output advances one entry on each accepted read.
- R10: After an active-low reset, both enables are taken as 0 and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_buf_en | input | 1 | Buffering enabled for transmit |
| rx_buf_en | input | 1 | Buffering enabled for receive |
| ae_level | input | 7 | Almost-empty threshold (count at or below) |
| af_level | input | 7 | Almost-full threshold (count at or above) |
| tx_wr_en | input | 1 | Push a byte into the transmit FIFO |
| tx_wr_data | input | 8 | Byte to push into the transmit FIFO |
| tx_rd_en | input | 1 | Pop the oldest transmit byte |
| tx_rd_data | output | 8 | Oldest transmit byte (show-ahead) |
| rx_wr_en | input | 1 | Push a byte into the receive FIFO |
| rx_wr_data | input | 8 | Byte to push into the receive FIFO |
| rx_rd_en | input | 1 | Pop the oldest receive byte |
| rx_rd_data | output | 8 | Oldest receive byte (show-ahead) |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_almost_empty | output | 1 | Transmit count at or below `ae_level` |
| tx_almost_full | output | 1 | Transmit count at or above `af_level` |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_almost_empty | output | 1 | Receive count at or below `ae_level` |
| rx_almost_full | output | 1 | Receive count at or above `af_level` |

## Verification
The assertions assume that `af_level` stays within the split depth of 32 whenever they use it to infer the almost-full flag of a full FIFO. They also assume that the enable pair is held for at least one edge before the overflow and underflow properties are judged. Stimulus that steps outside either condition only switches the affected properties off, and the bench model still checks those cycles. The directed phases use levels of 4 and 28. The randomized phase draws levels from 0 to 64 and toggles the enables at random, which exercises the mode-change clear under heavy traffic. Inputs change only between clock edges, so every enable change lands cleanly on one edge.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

   typedef enum logic [1:0] {
      SDF_OFF  = 2'b00,
      SDF_TX   = 2'b01,
      SDF_RX   = 2'b10,
      SDF_BOTH = 2'b11
   } sdf_mode_e;

   // Capacity of one direction (0 = transmit, 1 = receive) in a mode.
   function automatic int unsigned sdf_cap(sdf_mode_e m, int unsigned dir, int unsigned depth);
      if (m == SDF_BOTH) return depth / 2;
      if (dir == 0) return (m == SDF_TX) ? depth : 0;
      return (m == SDF_RX) ? depth : 0;
   endfunction

   // First address of a direction's region in a mode.
   function automatic int unsigned sdf_base(sdf_mode_e m, int unsigned dir, int unsigned depth);
      if (m == SDF_BOTH && dir == 1) return depth / 2;
      return 0;
   endfunction

endpackage

// File: rtl/sdf_ptr_ctrl.sv
module sdf_ptr_ctrl #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic [AW-1:0] base,
   input  logic [AW:0]   cap,
   input  logic          wr_req,
   input  logic          rd_req,
   output logic          wr_fire,
   output logic          rd_fire,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic [AW:0]   count
);
   localparam int CW = AW + 1;

   logic [AW-1:0] wr_off, rd_off;
   logic [AW:0]   last;

   assign last    = cap - CW'(1);
   assign wr_fire = wr_req && (count != cap) && !clear;
   assign rd_fire = rd_req && (count != '0) && !clear;
   assign wr_addr = base + wr_off;
   assign rd_addr = base + rd_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_off <= '0;
         rd_off <= '0;
         count  <= '0;
      end else if (clear) begin
         wr_off <= '0;
         rd_off <= '0;
         count  <= '0;
      end else begin
         if (wr_fire)
            wr_off <= ({1'b0, wr_off} == last) ? '0 : wr_off + 1'b1;
         if (rd_fire)
            rd_off <= ({1'b0, rd_off} == last) ? '0 : rd_off + 1'b1;
         case ({wr_fire, rd_fire})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/sdf_store.sv
module sdf_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          we_a,
   input  logic [AW-1:0] wa_a,
   input  logic [DW-1:0] wd_a,
   input  logic          we_b,
   input  logic [AW-1:0] wa_b,
   input  logic [DW-1:0] wd_b,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   output logic [DW-1:0] rd_a,
   output logic [DW-1:0] rd_b
);
   logic [DW-1:0] mem [DEPTH];

   // Regions never overlap while both ports are live, so the two writes are disjoint.
   always_ff @(posedge clk) begin
      if (we_a) mem[wa_a] <= wd_a;
      if (we_b) mem[wa_b] <= wd_b;
   end

   assign rd_a = mem[ra_a];
   assign rd_b = mem[ra_b];
endmodule

// File: rtl/sdf_level_flags.sv
module sdf_level_flags #(
   parameter int AW = 6
) (
   input  logic [AW:0] count,
   input  logic [AW:0] cap,
   input  logic [AW:0] ae_lvl,
   input  logic [AW:0] af_lvl,
   output logic        empty,
   output logic        full,
   output logic        almost_empty,
   output logic        almost_full
);
   logic active;

   assign active       = (cap != '0);
   assign empty        = (count == '0);
   assign full         = (count == cap);
   assign almost_empty = active && (count <= ae_lvl);
   assign almost_full  = active && (count >= af_lvl);
endmodule

// File: rtl/shared_dir_fifo.sv
module shared_dir_fifo
   import sdf_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_buf_en,
   input  logic          rx_buf_en,
   input  logic [AW:0]   ae_level,
   input  logic [AW:0]   af_level,
   input  logic          tx_wr_en,
   input  logic [DW-1:0] tx_wr_data,
   input  logic          tx_rd_en,
   output logic [DW-1:0] tx_rd_data,
   input  logic          rx_wr_en,
   input  logic [DW-1:0] rx_wr_data,
   input  logic          rx_rd_en,
   output logic [DW-1:0] rx_rd_data,
   output logic          tx_empty,
   output logic          tx_full,
   output logic          tx_almost_empty,
   output logic          tx_almost_full,
   output logic          rx_empty,
   output logic          rx_full,
   output logic          rx_almost_empty,
   output logic          rx_almost_full
);
   localparam int NDIR = 2;

   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("shared_dir_fifo: DEPTH must be a power of two of at least 4");
   end
   if (DW < 1) begin : g_bad_width
      $error("shared_dir_fifo: DW must be positive");
   end

   sdf_mode_e mode_in, mode_q;
   logic      mode_chg;

   assign mode_in  = sdf_mode_e'({rx_buf_en, tx_buf_en});
   assign mode_chg = (mode_in != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= SDF_OFF;
      else        mode_q <= mode_in;
   end

   logic          wr_req  [NDIR];
   logic          rd_req  [NDIR];
   logic          wr_fire [NDIR];
   logic          rd_fire [NDIR];
   logic [AW-1:0] wr_addr [NDIR];
   logic [AW-1:0] rd_addr [NDIR];
   logic [AW:0]   count   [NDIR];
   logic [AW:0]   cap     [NDIR];
   logic [AW-1:0] base    [NDIR];
   logic          f_empty [NDIR];
   logic          f_full  [NDIR];
   logic          f_ae    [NDIR];
   logic          f_af    [NDIR];

   assign wr_req[0] = tx_wr_en;
   assign rd_req[0] = tx_rd_en;
   assign wr_req[1] = rx_wr_en;
   assign rd_req[1] = rx_rd_en;

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      assign cap[d]  = CW'(sdf_cap(mode_q, d, DEPTH));
      assign base[d] = AW'(sdf_base(mode_q, d, DEPTH));

      sdf_ptr_ctrl #(.AW(AW)) u_ptr (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear   (mode_chg),
         .base    (base[d]),
         .cap     (cap[d]),
         .wr_req  (wr_req[d]),
         .rd_req  (rd_req[d]),
         .wr_fire (wr_fire[d]),
         .rd_fire (rd_fire[d]),
         .wr_addr (wr_addr[d]),
         .rd_addr (rd_addr[d]),
         .count   (count[d])
      );

      sdf_level_flags #(.AW(AW)) u_flags (
         .count        (count[d]),
         .cap          (cap[d]),
         .ae_lvl       (ae_level),
         .af_lvl       (af_level),
         .empty        (f_empty[d]),
         .full         (f_full[d]),
         .almost_empty (f_ae[d]),
         .almost_full  (f_af[d])
      );
   end

   sdf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk  (clk),
      .we_a (wr_fire[0]),
      .wa_a (wr_addr[0]),
      .wd_a (tx_wr_data),
      .we_b (wr_fire[1]),
      .wa_b (wr_addr[1]),
      .wd_b (rx_wr_data),
      .ra_a (rd_addr[0]),
      .ra_b (rd_addr[1]),
      .rd_a (tx_rd_data),
      .rd_b (rx_rd_data)
   );

   assign tx_empty        = f_empty[0];
   assign tx_full         = f_full[0];
   assign tx_almost_empty = f_ae[0];
   assign tx_almost_full  = f_af[0];
   assign rx_empty        = f_empty[1];
   assign rx_full         = f_full[1];
   assign rx_almost_empty = f_ae[1];
   assign rx_almost_full  = f_af[1];
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
   parameter int AW = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic        tx_buf_en,
   input logic        rx_buf_en,
   input logic [AW:0] af_level,
   input logic        tx_wr_en,
   input logic        tx_rd_en,
   input logic        rx_wr_en,
   input logic        rx_rd_en,
   input logic        tx_empty,
   input logic        tx_full,
   input logic        tx_almost_empty,
   input logic        tx_almost_full,
   input logic        rx_empty,
   input logic        rx_full,
   input logic        rx_almost_empty,
   input logic        rx_almost_full
);
   localparam int HALF = (1 << AW) / 2;

   logic [1:0] en_prev;
   logic       steady;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_prev <= 2'b00;
      else        en_prev <= {rx_buf_en, tx_buf_en};
   end
   assign steady = (en_prev == {rx_buf_en, tx_buf_en});

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (steady && tx_full && tx_wr_en && !tx_rd_en) |=> tx_full);

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (steady && rx_empty && rx_rd_en && !rx_wr_en) |=> rx_empty);

   p_clear_on_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !steady |=> (tx_empty && rx_empty));

   p_tx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (steady && !tx_buf_en) |-> (tx_empty && tx_full && !tx_almost_empty && !tx_almost_full));

   p_rx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (steady && !rx_buf_en) |-> (rx_empty && rx_full && !rx_almost_empty && !rx_almost_full));

   p_empty_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (steady && tx_buf_en && tx_empty) |-> tx_almost_empty);

   p_full_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (steady && rx_buf_en && rx_full && af_level <= (AW+1)'(HALF)) |-> rx_almost_full);

   p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (steady && tx_buf_en && rx_buf_en) |-> !(tx_empty && tx_full) && !(rx_empty && rx_full));
endmodule

bind shared_dir_fifo sdf_checker #(.AW(AW)) u_sdf_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .tx_buf_en       (tx_buf_en),
   .rx_buf_en       (rx_buf_en),
   .af_level        (af_level),
   .tx_wr_en        (tx_wr_en),
   .tx_rd_en        (tx_rd_en),
   .rx_wr_en        (rx_wr_en),
   .rx_rd_en        (rx_rd_en),
   .tx_empty        (tx_empty),
   .tx_full         (tx_full),
   .tx_almost_empty (tx_almost_empty),
   .tx_almost_full  (tx_almost_full),
   .rx_empty        (rx_empty),
   .rx_full         (rx_full),
   .rx_almost_empty (rx_almost_empty),
   .rx_almost_full  (rx_almost_full)
);

// File: tb/shared_dir_fifo_test.sv
module shared_dir_fifo_test;
   localparam int DW = 8;
   localparam int DEPTH = 64;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_buf_en = 1'b0, rx_buf_en = 1'b0;
   logic [AW:0]   ae_level = 7'd4, af_level = 7'd28;
   logic          tx_wr_en = 1'b0, tx_rd_en = 1'b0, rx_wr_en = 1'b0, rx_rd_en = 1'b0;
   logic [DW-1:0] tx_wr_data = '0, rx_wr_data = '0;
   logic [DW-1:0] tx_rd_data, rx_rd_data;
   logic          tx_empty, tx_full, tx_almost_empty, tx_almost_full;
   logic          rx_empty, rx_full, rx_almost_empty, rx_almost_full;

   always #2.5 clk = ~clk;

   shared_dir_fifo #(.DW(DW), .DEPTH(DEPTH)) uut (.*);

   int vectors = 0;
   int errors = 0;
   string cur_req = "R10";
   bit checking = 1'b0;

   logic [DW-1:0] txq[$];
   logic [DW-1:0] rxq[$];
   int mdl_mode = 0;

   function automatic int cap_of(int m, int dir);
      if (m == 3) return DEPTH / 2;
      if (dir == 0) return (m == 1) ? DEPTH : 0;
      return (m == 2) ? DEPTH : 0;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Reference model update on every rising edge.
   always @(posedge clk) begin
      if (rst_n) begin
         int m_in;
         m_in = {rx_buf_en, tx_buf_en};
         if (m_in != mdl_mode) begin
            txq.delete();
            rxq.delete();
            mdl_mode = m_in;
         end else begin
            bit tw, tr, rw, rr;
            tw = tx_wr_en && txq.size() < cap_of(mdl_mode, 0);
            tr = tx_rd_en && txq.size() > 0;
            rw = rx_wr_en && rxq.size() < cap_of(mdl_mode, 1);
            rr = rx_rd_en && rxq.size() > 0;
            if (tr) void'(txq.pop_front());
            if (tw) txq.push_back(tx_wr_data);
            if (rr) void'(rxq.pop_front());
            if (rw) rxq.push_back(rx_wr_data);
         end
      end
   end

   // Compare every output on the falling edge.
   always @(negedge clk) begin
      if (checking) begin
         int tc, rc, tn, rn;
         tc = cap_of(mdl_mode, 0);
         rc = cap_of(mdl_mode, 1);
         tn = txq.size();
         rn = rxq.size();
         chk(cur_req, "tx_empty", tx_empty, tn == 0);
         chk(cur_req, "tx_full", tx_full, tn == tc);
         chk(cur_req, "rx_empty", rx_empty, rn == 0);
         chk(cur_req, "rx_full", rx_full, rn == rc);
         chk("R7", "tx_almost_empty", tx_almost_empty, tc > 0 && tn <= int'(ae_level));
         chk("R7", "rx_almost_empty", rx_almost_empty, rc > 0 && rn <= int'(ae_level));
         chk("R8", "tx_almost_full", tx_almost_full, tc > 0 && tn >= int'(af_level));
         chk("R8", "rx_almost_full", rx_almost_full, rc > 0 && rn >= int'(af_level));
         if (tn > 0) chk("R9", "tx_rd_data", tx_rd_data, txq[0]);
         if (rn > 0) chk("R9", "rx_rd_data", rx_rd_data, rxq[0]);
      end
   end

   task automatic step(bit tw, bit tr, bit rw, bit rr);
      @(posedge clk);
      #1;
      tx_wr_en = tw;
      tx_rd_en = tr;
      rx_wr_en = rw;
      rx_rd_en = rr;
      tx_wr_data = DW'($urandom);
      rx_wr_data = DW'($urandom);
   endtask

   task automatic set_mode(bit t, bit r);
      @(posedge clk);
      #1;
      tx_buf_en = t;
      rx_buf_en = r;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      checking = 1'b1;
      cur_req = "R10";
      repeat (2) step(0, 0, 0, 0);

      // R1 and R4: transmit-only, overfill then overdrain
      cur_req = "R1";
      set_mode(1, 0);
      step(1, 0, 1, 0);
      for (int i = 0; i < 66; i++) step(1, 0, 0, 0);
      cur_req = "R4";
      step(1, 1, 0, 0);
      for (int i = 0; i < 66; i++) step(0, 1, 0, 0);
      step(1, 1, 0, 0);
      step(0, 0, 0, 0);

      // R2 and R6: receive-only, transmit side pushed but disabled
      cur_req = "R2";
      set_mode(0, 1);
      step(0, 0, 0, 0);
      for (int i = 0; i < 66; i++) step(1, 0, 1, 0);
      cur_req = "R6";
      for (int i = 0; i < 70; i++) step(1, 1, 0, 1);

      // R3: split, each direction 32 deep and independent
      cur_req = "R3";
      set_mode(1, 1);
      step(0, 0, 0, 0);
      for (int i = 0; i < 34; i++) step(1, 0, 0, 0);
      for (int i = 0; i < 34; i++) step(0, 0, 1, 0);
      for (int i = 0; i < 20; i++) step(0, 1, 1, 0);
      for (int i = 0; i < 40; i++) step(1, 1, 0, 1);

      // R5: mode change with traffic in flight empties both
      cur_req = "R5";
      for (int i = 0; i < 10; i++) step(1, 0, 1, 0);
      set_mode(1, 0);
      step(1, 1, 1, 1);
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
      set_mode(1, 1);
      step(1, 1, 1, 1);
      step(0, 0, 0, 0);

      // Mixed random traffic, levels and mode changes (R7, R8, R4, R5)
      cur_req = "R4";
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 199) == 0) set_mode(1'($urandom), 1'($urandom));
         if ($urandom_range(0, 49) == 0) begin
            ae_level = 7'($urandom_range(0, 64));
            af_level = 7'($urandom_range(0, 64));
         end
         step($urandom_range(0, 99) < 55, $urandom_range(0, 99) < 45,
              $urandom_range(0, 99) < 45, $urandom_range(0, 99) < 55);
      end
      step(0, 0, 0, 0);
      @(negedge clk);
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule